// File: doc/BRIEF.md
# Timer-Derived Serial Bit Clock Generator

This block makes the bit timing for an asynchronous/synchronous serial port from a general-purpose countdown timer. The timer runs from a 2.4576 MHz reference clock. It passes through a selectable prescaler whose smallest ratio is 4, and then through an 8-bit reload counter. Each time the counter expires, the timer output pin changes state. One full period of the resulting serial clock therefore spans two expiries.

The serial clock then drives two divide stages. The transmit side can use the serial clock directly (divide-by-1), for synchronous links or for fast transmit-only output. It can also divide it by 16, which gives the usual asynchronous rate: at the fastest timer setting that is 19200 bps, and divide-by-1 gives sixteen times that. The receive side always divides by 16, because an oversampling receiver has no other working ratio. This lets a link receive at the normal rate while it transmits at the fast one. The receive divider is re-phased when a falling start edge appears on the serial input, so that its strobe lands in the middle of each bit.

The block delivers two one-cycle strobes, one telling the transmit shifter to advance and one telling the receive sampler to take a bit. Character framing and the shift registers belong to the surrounding port.

Top module: `usart_baud_gen`

## Requirements
- R1: During and right after reset, `timer_out`, `tx_bit_stb` and `rx_bit_stb` are all 0.
- R2: `psc_sel` codes 1, 2, 3, 4, 5, 6 and 7 select prescale ratios P of 4, 10, 16, 50, 64, 100 and 200. With a reload span N, `timer_out` first changes P*N cycles after the first enabled cycle and then changes every P*N cycles.
- R3: A `reload_val` from 1 to 255 gives a span N equal to that value. A `reload_val` of 0 gives N = 256.
- R4: `psc_sel` code 0 stops the timer. While it is stopped, `timer_out` holds its level and neither strobe fires. The next enable restarts the full P*N count from zero.
- R5: With `div1_mode` = 1, `tx_bit_stb` is a one-cycle pulse in the first cycle `timer_out` reads 1 after each rising change, so strobes are 2*P*N cycles apart.
- R6: With `div1_mode` = 0, `tx_bit_stb` fires on every 16th rising change of `timer_out`, so strobes are 32*P*N cycles apart.
- R7: `rx_bit_stb` fires on every 16th rising change of `timer_out` whatever the value of `div1_mode`.
- R8: `rx_in` passes through a two-stage synchronizer. A falling edge detected after it sets the receive divider to its midpoint, so the next `rx_bit_stb` comes on the 8th rising change of `timer_out` after the re-phase.
- R9: If a re-phase and a rising change of `timer_out` happen in the same cycle, the re-phase wins. That rising change is not counted and gives no receive strobe, so the next `rx_bit_stb` comes on the 9th rising change counting that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Timer reference clock (2.4576 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| psc_sel | input | 3 | Prescaler code: 0 stop, 1..7 ratio 4/10/16/50/64/100/200 |
| reload_val | input | 8 | Reload span of the countdown (0 means 256) |
| div1_mode | input | 1 | Transmit ratio: 1 = divide-by-1, 0 = divide-by-16 |
| rx_in | input | 1 | Serial receive line, idle high, used for start-edge re-phasing |
| timer_out | output | 1 | Timer output pin; toggles on each expiry |
| tx_bit_stb | output | 1 | One-cycle transmit bit strobe |
| rx_bit_stb | output | 1 | One-cycle receive bit strobe (always divide-by-16) |

## Verification
The receive start-edge re-phase and a rising change of the timer output can act on the receive divider in the same clock. The bench sets up this collision on purpose. It runs the shortest timer period, watches one rising change, and then drives `rx_in` low at exactly the point where the two-stage synchronizer delivers the edge together with the next rising change. It also drives a second edge well away from any rising change. It then counts the rising changes up to the first receive strobe: 9 in the colliding case and 8 in the clean case. This shows that the re-phase wins and the colliding rise is swallowed.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

  localparam int PSC_SEL_W = 3;
  localparam int PSC_CNT_W = 8;

  typedef enum logic [PSC_SEL_W-1:0] {
    PS_STOP = 3'd0,
    PS_4    = 3'd1,
    PS_10   = 3'd2,
    PS_16   = 3'd3,
    PS_50   = 3'd4,
    PS_64   = 3'd5,
    PS_100  = 3'd6,
    PS_200  = 3'd7
  } psc_code_e;

  // Divide ratio of a prescaler code; 0 for the stopped code.
  function automatic logic [PSC_CNT_W-1:0] psc_ratio(input logic [PSC_SEL_W-1:0] code);
    case (psc_code_e'(code))
      PS_4:    return 8'd4;
      PS_10:   return 8'd10;
      PS_16:   return 8'd16;
      PS_50:   return 8'd50;
      PS_64:   return 8'd64;
      PS_100:  return 8'd100;
      PS_200:  return 8'd200;
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/ubg_prescaler.sv
module ubg_prescaler
  import ubg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PSC_SEL_W-1:0] sel,
  output logic                 run,
  output logic                 tick
);
  logic [PSC_CNT_W-1:0] cnt;
  logic [PSC_CNT_W-1:0] last;

  assign run  = (sel != PS_STOP);
  assign last = psc_ratio(sel) - PSC_CNT_W'(1);
  // >= keeps the counter bounded if the ratio shrinks mid-count
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + PSC_CNT_W'(1);
  end
endmodule

// File: rtl/ubg_reload_timer.sv
module ubg_reload_timer #(
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                tick,
  input  logic [RELOAD_W-1:0] reload_val,
  output logic                expire,
  output logic                rise,
  output logic                tout
);
  localparam int CNT_W = RELOAD_W + 1;

  // Zero reload stands for the full 2**RELOAD_W span.
  function automatic logic [CNT_W-1:0] span_of(input logic [RELOAD_W-1:0] r);
    if (r == '0) return {1'b1, {RELOAD_W{1'b0}}};
    return {1'b0, r};
  endfunction

  logic [CNT_W-1:0] cnt;

  assign expire = run && tick && (cnt <= CNT_W'(1));
  assign rise   = expire && !tout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tout <= 1'b0;
    end else if (!run) begin
      cnt  <= span_of(reload_val);
    end else if (tick) begin
      if (expire) begin
        cnt  <= span_of(reload_val);
        tout <= ~tout;
      end else begin
        cnt  <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ubg_line_sync.sv
module ubg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-1:0], din};
  end

  assign fall = q[STAGES] && !q[STAGES-1];
endmodule

// File: rtl/ubg_bit_divider.sv
module ubg_bit_divider #(
  parameter int LOG2    = 4,
  parameter bit REPHASE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic restart,
  output logic wrap
);
  localparam logic [LOG2-1:0] TOP = '1;
  localparam logic [LOG2-1:0] MID = LOG2'(1 << (LOG2 - 1));

  logic [LOG2-1:0] cnt;
  logic            do_restart;

  generate
    if (REPHASE) begin : g_rephase
      assign do_restart = restart;
    end else begin : g_free
      assign do_restart = 1'b0 & restart;
    end
  endgenerate

  // A restart swallows a coincident rise.
  assign wrap = rise && !do_restart && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (do_restart) cnt <= MID;
    else if (rise)       cnt <= cnt + LOG2'(1);
  end
endmodule

// File: rtl/usart_baud_gen.sv
module usart_baud_gen
  import ubg_pkg::*;
#(
  parameter int RELOAD_W    = 8,
  parameter int DIV_LOG2    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_ref,
  input  logic                 rst_n,
  input  logic [PSC_SEL_W-1:0] psc_sel,
  input  logic [RELOAD_W-1:0]  reload_val,
  input  logic                 div1_mode,
  input  logic                 rx_in,
  output logic                 timer_out,
  output logic                 tx_bit_stb,
  output logic                 rx_bit_stb
);
  // Named internal events, watched by the checker.
  logic tmr_run;
  logic tmr_tick;
  logic tmr_expire;
  logic ser_rise;
  logic rx_start;
  logic tx_wrap;
  logic rx_wrap;

  ubg_prescaler u_psc (
    .clk  (clk_ref),
    .rst_n(rst_n),
    .sel  (psc_sel),
    .run  (tmr_run),
    .tick (tmr_tick)
  );

  ubg_reload_timer #(.RELOAD_W(RELOAD_W)) u_tmr (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .run       (tmr_run),
    .tick      (tmr_tick),
    .reload_val(reload_val),
    .expire    (tmr_expire),
    .rise      (ser_rise),
    .tout      (timer_out)
  );

  ubg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk_ref),
    .rst_n(rst_n),
    .din  (rx_in),
    .fall (rx_start)
  );

  ubg_bit_divider #(.LOG2(DIV_LOG2), .REPHASE(1'b0)) u_txdiv (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .rise   (ser_rise),
    .restart(1'b0),
    .wrap   (tx_wrap)
  );

  ubg_bit_divider #(.LOG2(DIV_LOG2), .REPHASE(1'b1)) u_rxdiv (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .rise   (ser_rise),
    .restart(rx_start),
    .wrap   (rx_wrap)
  );

  // Strobes register in the same edge that raises timer_out.
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit_stb <= 1'b0;
      rx_bit_stb <= 1'b0;
    end else begin
      tx_bit_stb <= div1_mode ? ser_rise : tx_wrap;
      rx_bit_stb <= rx_wrap;
    end
  end
endmodule

// File: rtl/ubg_checker.sv
module ubg_checker (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [2:0] psc_sel,
  input logic       div1_mode,
  input logic       timer_out,
  input logic       tx_bit_stb,
  input logic       rx_bit_stb,
  input logic       tmr_tick,
  input logic       tmr_expire,
  input logic       ser_rise,
  input logic       rx_start
);
  p_expire_on_tick_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tmr_expire |-> tmr_tick);

  p_toggle_needs_expire_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(timer_out) |-> $past(tmr_expire));

  p_stop_holds_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (psc_sel == 3'd0) |=> $stable(timer_out));

  p_stop_quiet_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (psc_sel == 3'd0) |=> (!tx_bit_stb && !rx_bit_stb));

  p_x1_follows_rise_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ser_rise && div1_mode) |=> tx_bit_stb);

  p_tx_on_rise_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    tx_bit_stb |-> $rose(timer_out));

  p_rx_on_rise_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rx_bit_stb |-> $rose(timer_out));

  p_rephase_quiet_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rx_start |=> !rx_bit_stb);
endmodule

bind usart_baud_gen ubg_checker u_chk (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .psc_sel   (psc_sel),
  .div1_mode (div1_mode),
  .timer_out (timer_out),
  .tx_bit_stb(tx_bit_stb),
  .rx_bit_stb(rx_bit_stb),
  .tmr_tick  (tmr_tick),
  .tmr_expire(tmr_expire),
  .ser_rise  (ser_rise),
  .rx_start  (rx_start)
);

// File: tb/usart_baud_gen_tb.sv
module usart_baud_gen_tb;
  localparam int LIM = 6000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] psc_sel;
  logic [7:0] reload_val;
  logic       div1_mode;
  logic       rx_in;
  logic       timer_out, tx_bit_stb, rx_bit_stb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  usart_baud_gen u_dut (
    .clk_ref   (clk),
    .rst_n     (rst_n),
    .psc_sel   (psc_sel),
    .reload_val(reload_val),
    .div1_mode (div1_mode),
    .rx_in     (rx_in),
    .timer_out (timer_out),
    .tx_bit_stb(tx_bit_stb),
    .rx_bit_stb(rx_bit_stb)
  );

  function automatic int ratio_of(input int code);
    int t[8] = '{0, 4, 10, 16, 50, 64, 100, 200};
    return t[code];
  endfunction

  function automatic int span_of(input int r);
    return (r == 0) ? 256 : r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Stop for one edge (loads reload), then enable on the next edge.
  task automatic start_run(input int code, input int rl);
    step();
    psc_sel    = 3'd0;
    reload_val = 8'(rl);
    step();
    psc_sel    = 3'(code);
  endtask

  task automatic toggle_timing(input int code, input int rl, input string tag);
    int n;
    logic t0;
    int exp;
    exp = ratio_of(code) * span_of(rl);
    start_run(code, rl);
    t0 = timer_out;
    n  = 0;
    do begin step(); n++; end while (timer_out == t0 && n < LIM);
    check(n == exp, {tag, " first toggle"}, n, exp);
    t0 = timer_out;
    n  = 0;
    do begin step(); n++; end while (timer_out == t0 && n < LIM);
    check(n == exp, {tag, " toggle period"}, n, exp);
  endtask

  function automatic logic pick(input int which);
    return (which == 0) ? tx_bit_stb : rx_bit_stb;
  endfunction

  task automatic strobe_interval(input int which, input int exp, input string tag);
    int n;
    n = 0;
    while (!pick(which) && n < LIM) begin step(); n++; end
    check(timer_out == 1'b1, {tag, " strobe with timer high"}, int'(timer_out), 1);
    n = 0;
    do begin step(); n++; end while (!pick(which) && n < LIM);
    check(n == exp, {tag, " strobe spacing"}, n, exp);
  endtask

  // Wait for a rise, drive the start edge 'offs' negedges later, count rises to rx strobe.
  task automatic rephase_test(input int offs, input int exp, input string tag);
    int n, rises;
    logic prev;
    n = 0;
    prev = timer_out;
    do begin prev = timer_out; step(); n++; end while (!(timer_out && !prev) && n < LIM);
    repeat (offs) step();
    rx_in = 1'b0;
    rises = 0;
    n = 0;
    prev = timer_out;
    do begin
      prev = timer_out;
      step();
      n++;
      if (timer_out && !prev) rises++;
    end while (!rx_bit_stb && n < LIM);
    check(rises == exp, tag, rises, exp);
    rx_in = 1'b1;
    repeat (40) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic t0;
    bit quiet;
    rst_n = 1'b0; psc_sel = 3'd0; reload_val = 8'd1; div1_mode = 1'b0; rx_in = 1'b1;
    repeat (4) step();
    // R1: outputs idle in reset and just after release
    check(timer_out == 1'b0, "R1 timer_out in reset", int'(timer_out), 0);
    check(tx_bit_stb == 1'b0, "R1 tx_bit_stb in reset", int'(tx_bit_stb), 0);
    check(rx_bit_stb == 1'b0, "R1 rx_bit_stb in reset", int'(rx_bit_stb), 0);
    rst_n = 1'b1;
    step();
    check(!timer_out && !tx_bit_stb && !rx_bit_stb, "R1 idle after release",
          int'({timer_out, tx_bit_stb, rx_bit_stb}), 0);

    // R2: every prescaler code, reload 3
    for (int c = 1; c < 8; c++) toggle_timing(c, 3, $sformatf("R2 code %0d", c));

    // R3: reload sweep including 0 -> 256
    begin
      int rls[5] = '{1, 2, 5, 255, 0};
      foreach (rls[i]) toggle_timing(1, rls[i], $sformatf("R3 reload %0d", rls[i]));
    end

    // R5: divide-by-1 transmit, P=10 N=2 -> 40 cycles
    div1_mode = 1'b1;
    start_run(2, 2);
    strobe_interval(0, 40, "R5 x1");
    strobe_interval(0, 40, "R5 x1 again");

    // R6: divide-by-16 transmit, P=4 N=1 -> 128 cycles
    div1_mode = 1'b0;
    start_run(1, 1);
    strobe_interval(0, 128, "R6 x16");

    // R7: receive stays divide-by-16 while transmit is x1
    div1_mode = 1'b1;
    start_run(1, 1);
    strobe_interval(1, 128, "R7 rx in x1 mode");
    strobe_interval(0, 8, "R7 tx still x1");

    // R8: clean start edge -> 8th rise
    rephase_test(1, 8, "R8 midpoint re-phase");
    // R9: start edge lands with a rise -> that rise swallowed, 9th
    rephase_test(5, 9, "R9 re-phase beats rise");
    strobe_interval(1, 128, "R8 rx spacing after re-phase");

    // R4: stop holds pin, no strobes; restart counts afresh
    step();
    psc_sel = 3'd0;
    t0 = timer_out;
    quiet = 1'b1;
    for (int i = 0; i < 200; i++) begin
      step();
      if (timer_out != t0 || tx_bit_stb || rx_bit_stb) quiet = 1'b0;
    end
    check(quiet, "R4 stopped timer quiet", int'(quiet), 1);
    psc_sel = 3'd3;
    n = 0;
    do begin step(); n++; end while (timer_out == t0 && n < LIM);
    check(n == 16, "R4 restart full count", n, 16);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule